// File: doc/BRIEF.md
# Scratchpad Block Transfer Engine

This block sits between a two-page on-chip scratchpad and one external memory port. It moves 32-byte blocks between them without any cache. A command port accepts two kinds of request. A prefetch fills a scratchpad block from external memory. A write-back copies a scratchpad block out to external memory. Each command carries a scratchpad byte address and an external physical address that has already been translated, 29 bits wide. The block ignores the low five bits of both addresses, so every transfer starts on a 32-byte boundary.

The CPU load/store port stays connected to the scratchpad for the whole time. The scratchpad is built as two independent banks, one per page. A CPU access to the page that is not being transferred completes in one cycle as usual. A CPU access to the page under transfer is held off with a stall until the transfer ends. The external side is a beat-based request/acknowledge bus with 64-bit beats, so one block takes four beats. Only one transfer is in flight at a time. Any further command waits on a ready/valid handshake.

Top module: `lmem_xfer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `ext_req`, `cpu_stall` and `xfer_done` are 0.
- R2: With no page conflict, the CPU port works as follows. A write with `cpu_req`=1 and `cpu_we`=1 stores the full 64-bit word at the next clock edge. A read is taken at a clock edge and its data is on `cpu_rdata` in the cycle that follows. Address bits [2:0] are ignored.
- R3: A command with `cmd_op`=0 (prefetch) makes four read beats on the external port (`ext_we`=0). Beat i's `ext_rdata` is written to scratchpad word i of the addressed block.
- R4: A command with `cmd_op`=1 (write-back) makes four write beats (`ext_we`=1). Beat i carries scratchpad word i of the addressed block on `ext_wdata`.
- R5: The low five bits of `cmd_sp_addr` and `cmd_ext_addr` are treated as zero. Beat i uses `ext_addr` = aligned base + 8*i, over all 29 bits.
- R6: The page is bit 7 of a scratchpad address, and the block within the page is bits [6:5]. During a transfer, CPU accesses to the other page see `cpu_stall`=0 and complete as in R2.
- R7: During a transfer, a CPU access to the page under transfer sees `cpu_stall`=1. The access, a write included, is not performed while it is stalled.
- R8: `xfer_done` is 1 for exactly the one cycle after the edge that takes the final beat. `cpu_stall` is already 0 in that cycle.
- R9: `cmd_ready` is 0 from the edge that accepts a command until the cycle after `xfer_done`. A command held valid during that time is accepted then.
- R10: `ext_req`, `ext_addr`, `ext_we` and `ext_wdata` are held stable until a clock edge at which `ext_ack` is 1. That edge completes the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU scratchpad access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 8 | CPU scratchpad byte address |
| cpu_wdata | input | 64 | CPU write data |
| cpu_rdata | output | 64 | CPU read data, one cycle after the read |
| cpu_stall | output | 1 | CPU access blocked by a page conflict |
| cmd_valid | input | 1 | Transfer command valid |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 1 | 0 = prefetch, 1 = write-back |
| cmd_sp_addr | input | 8 | Scratchpad block address |
| cmd_ext_addr | input | 29 | External physical block address |
| ext_req | output | 1 | External beat request |
| ext_we | output | 1 | External beat is a write |
| ext_addr | output | 29 | External beat address |
| ext_wdata | output | 64 | External write data |
| ext_ack | input | 1 | External beat acknowledge |
| ext_rdata | input | 64 | External read data, valid with ack |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
The hardest case to reach is a CPU access to the busy page that is still pending at the moment the transfer completes. It must stall up to the final beat and then be served in the done cycle, and a stalled write must not reach the bank. The bench slows the external acknowledge by several cycles so the transfer stays open. While it is open, the bench tries a write to the busy page, then holds a read to that page until the done pulse, and checks the stall level every cycle. A command held valid behind a running transfer shows the ready/done ordering.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
    localparam int EXT_AW      = 29;
    localparam int BLOCK_BYTES = 32;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOAD,
        ENG_SEND,
        ENG_DONE
    } eng_state_e;

    typedef enum logic {
        OP_PREFETCH  = 1'b0,
        OP_WRITEBACK = 1'b1
    } xfer_op_e;
endpackage

// File: rtl/lbt_bank.sv
module lbt_bank #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Single port: a write stores, a read registers the word for the next cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[idx] <= wdata;
            end else begin
                rdata_q <= mem_q[idx];
            end
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/lbt_engine.sv
module lbt_engine
    import lbt_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int PAGE_BYTES = 128,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int BEATS      = BLOCK_BYTES / WORD_BYTES,
    localparam int BEAT_W     = $clog2(BEATS),
    localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES,
    localparam int IDX_W      = $clog2(PAGE_WORDS),
    localparam int SP_AW      = $clog2(2 * PAGE_BYTES),
    localparam int OFF_W      = $clog2(BLOCK_BYTES),
    localparam int BLK_W      = IDX_W - BEAT_W,
    localparam int BYTE_SH    = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [SP_AW-1:0]  cmd_sp_addr,
    input  logic [EXT_AW-1:0] cmd_ext_addr,
    output logic              ext_req,
    output logic              ext_we,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              eng_active,
    output logic              eng_page,
    output logic              eng_en,
    output logic              eng_we,
    output logic [IDX_W-1:0]  eng_idx,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              xfer_done
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        eng_state_e              st;
        xfer_op_e                op;
        logic                    page;
        logic [BLK_W-1:0]        blk;
        logic [EXT_AW-OFF_W-1:0] base;
        logic [BEAT_W-1:0]       beat;
    } eng_regs_t;

    eng_regs_t d, q;

    always_comb begin
        d         = q;
        cmd_ready = (q.st == ENG_IDLE);
        ext_req   = 1'b0;
        eng_en    = 1'b0;
        eng_we    = 1'b0;
        xfer_done = (q.st == ENG_DONE);
        case (q.st)
            ENG_IDLE: begin
                if (cmd_valid) begin
                    d.op   = xfer_op_e'(cmd_op);
                    d.page = cmd_sp_addr[SP_AW-1];
                    d.blk  = cmd_sp_addr[SP_AW-2:OFF_W];
                    d.base = cmd_ext_addr[EXT_AW-1:OFF_W];
                    d.beat = '0;
                    d.st   = cmd_op ? ENG_LOAD : ENG_SEND;
                end
            end
            ENG_LOAD: begin
                // Fetch the outgoing word; it is on bank_rdata next cycle.
                eng_en = 1'b1;
                d.st   = ENG_SEND;
            end
            ENG_SEND: begin
                ext_req = 1'b1;
                if (ext_ack) begin
                    if (q.op == OP_PREFETCH) begin
                        eng_en = 1'b1;
                        eng_we = 1'b1;
                    end
                    d.beat = q.beat + 1'b1;
                    if (q.beat == LAST_BEAT) begin
                        d.st = ENG_DONE;
                    end else begin
                        d.st = (q.op == OP_WRITEBACK) ? ENG_LOAD : ENG_SEND;
                    end
                end
            end
            ENG_DONE: begin
                d.st = ENG_IDLE;
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ENG_IDLE, op: OP_PREFETCH, page: 1'b0,
                   blk: '0, base: '0, beat: '0};
        end else begin
            q <= d;
        end
    end

    assign ext_we     = (q.op == OP_WRITEBACK);
    assign ext_addr   = {q.base, q.beat, {BYTE_SH{1'b0}}};
    assign ext_wdata  = bank_rdata;
    assign eng_active = (q.st == ENG_LOAD) || (q.st == ENG_SEND);
    assign eng_page   = q.page;
    assign eng_idx    = {q.blk, q.beat};
    assign eng_wdata  = ext_rdata;
endmodule

// File: rtl/lmem_xfer.sv
module lmem_xfer
    import lbt_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int PAGE_BYTES = 128,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES,
    localparam int IDX_W      = $clog2(PAGE_WORDS),
    localparam int SP_AW      = $clog2(2 * PAGE_BYTES),
    localparam int BYTE_SH    = $clog2(WORD_BYTES),
    localparam int NPAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [SP_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [SP_AW-1:0]  cmd_sp_addr,
    input  logic [EXT_AW-1:0] cmd_ext_addr,
    output logic              ext_req,
    output logic              ext_we,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              xfer_done
);
    logic              eng_active, eng_page, eng_en, eng_we;
    logic [IDX_W-1:0]  eng_idx;
    logic [DATA_W-1:0] eng_wdata;
    logic [DATA_W-1:0] bank_rd [NPAGES];

    logic              cpu_page;
    logic [IDX_W-1:0]  cpu_idx;
    logic              cpu_go;
    logic              rd_page_d, rd_page_q;

    assign cpu_page  = cpu_addr[SP_AW-1];
    assign cpu_idx   = cpu_addr[SP_AW-2:BYTE_SH];
    assign cpu_stall = cpu_req && eng_active && (cpu_page == eng_page);
    assign cpu_go    = cpu_req && !cpu_stall;

    lbt_engine #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (cmd_op),
        .cmd_sp_addr  (cmd_sp_addr),
        .cmd_ext_addr (cmd_ext_addr),
        .ext_req      (ext_req),
        .ext_we       (ext_we),
        .ext_addr     (ext_addr),
        .ext_wdata    (ext_wdata),
        .ext_ack      (ext_ack),
        .ext_rdata    (ext_rdata),
        .eng_active   (eng_active),
        .eng_page     (eng_page),
        .eng_en       (eng_en),
        .eng_we       (eng_we),
        .eng_idx      (eng_idx),
        .eng_wdata    (eng_wdata),
        .bank_rdata   (bank_rd[eng_page]),
        .xfer_done    (xfer_done)
    );

    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        logic              own, bk_en, bk_we;
        logic [IDX_W-1:0]  bk_idx;
        logic [DATA_W-1:0] bk_wdata;

        // The engine owns the bank of its page while active; the CPU has it otherwise.
        assign own      = eng_active && (eng_page == 1'(p));
        assign bk_en    = own ? eng_en    : (cpu_go && (cpu_page == 1'(p)));
        assign bk_we    = own ? eng_we    : cpu_we;
        assign bk_idx   = own ? eng_idx   : cpu_idx;
        assign bk_wdata = own ? eng_wdata : cpu_wdata;

        lbt_bank #(.DATA_W(DATA_W), .DEPTH(PAGE_WORDS)) u_bank (
            .clk   (clk),
            .en    (bk_en),
            .we    (bk_we),
            .idx   (bk_idx),
            .wdata (bk_wdata),
            .rdata (bank_rd[p])
        );
    end

    always_comb begin
        rd_page_d = rd_page_q;
        if (cpu_go && !cpu_we) begin
            rd_page_d = cpu_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_page_q <= 1'b0;
        end else begin
            rd_page_q <= rd_page_d;
        end
    end

    assign cpu_rdata = bank_rd[rd_page_q];
endmodule

// File: rtl/lbt_checker.sv
module lbt_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_stall,
    input logic              cmd_ready,
    input logic              ext_req,
    input logic              ext_we,
    input logic [28:0]       ext_addr,
    input logic [DATA_W-1:0] ext_wdata,
    input logic              ext_ack,
    input logic              xfer_done
);
    a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)
                                   && $stable(ext_wdata)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(ext_req && ext_ack));

    a_r8_no_stall_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !cpu_stall);

    a_r7_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> cpu_req);

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req || xfer_done) |-> !cmd_ready);

    a_r5_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (ext_addr[2:0] == 3'b000));
endmodule

bind lmem_xfer lbt_checker #(.DATA_W(DATA_W)) u_lbt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_stall (cpu_stall),
    .cmd_ready (cmd_ready),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_ack   (ext_ack),
    .xfer_done (xfer_done)
);

// File: tb/tb_lmem_xfer.sv
module tb_lmem_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [63:0] cpu_wdata = '0;
    logic [63:0] cpu_rdata;
    logic        cpu_stall;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_sp_addr = '0;
    logic [28:0] cmd_ext_addr = '0;
    logic        ext_req, ext_we;
    logic [28:0] ext_addr;
    logic [63:0] ext_wdata;
    logic        ext_ack = 1'b0;
    logic [63:0] ext_rdata = '0;
    logic        xfer_done;

    int n_vec = 0;
    int n_bad = 0;
    int ack_delay = 0;
    bit finished = 1'b0;

    logic [28:0] log_addr [64];
    logic        log_we   [64];
    logic [63:0] log_data [64];
    int          log_n = 0;

    lmem_xfer dut (.*);

    always #4 clk = ~clk;

    function automatic logic [63:0] pat(input logic [28:0] a);
        return {3'b010, a, ~a, 3'b011};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // External memory responder: read data is a function of the address; writes are logged.
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (ext_ack) begin
                ext_ack = 1'b0;
                wcnt = 0;
            end else if (ext_req) begin
                if (wcnt >= ack_delay) begin
                    ext_ack = 1'b1;
                    ext_rdata = pat(ext_addr);
                    if (log_n < 64) begin
                        log_addr[log_n] = ext_addr;
                        log_we[log_n]   = ext_we;
                        log_data[log_n] = ext_wdata;
                        log_n++;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic cpu_write(input logic [7:0] a, input logic [63:0] v);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [63:0] v);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        #1 v = cpu_rdata;
    endtask

    task automatic issue(input logic op, input logic [7:0] sp, input logic [28:0] ea);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sp_addr = sp; cmd_ext_addr = ea;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 500 && !seen; i++) begin
            @(negedge clk);
            #1 if (xfer_done) seen = 1'b1;
        end
        chk(seen, req, "done pulse seen", 64'(seen), 64'd1);
        @(negedge clk);
        #1 chk(!xfer_done, "R8", "done lasts one cycle", 64'(xfer_done), 64'd0);
    endtask

    task automatic t_reset();
        #1;
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 64'(cmd_ready), 64'd1);
        chk(ext_req == 1'b0, "R1", "ext_req after reset", 64'(ext_req), 64'd0);
        chk(cpu_stall == 1'b0, "R1", "stall after reset", 64'(cpu_stall), 64'd0);
        chk(xfer_done == 1'b0, "R1", "done after reset", 64'(xfer_done), 64'd0);
    endtask

    task automatic t_cpu_rw();
        logic [63:0] v;
        cpu_write(8'h10, 64'h0123_4567_89AB_CDEF);
        cpu_write(8'h93, 64'hFEDC_BA98_7654_3210);   // low bits ignored: word 0x90
        cpu_read(8'h17, v);                           // word 0x10
        chk(v == 64'h0123_4567_89AB_CDEF, "R2", "page0 readback", v, 64'h0123_4567_89AB_CDEF);
        cpu_read(8'h90, v);
        chk(v == 64'hFEDC_BA98_7654_3210, "R2", "page1 readback", v, 64'hFEDC_BA98_7654_3210);
    endtask

    task automatic t_prefetch();
        logic [63:0] v;
        int base_n = log_n;
        ack_delay = 0;
        issue(1'b0, 8'hBF, 29'h1234_567F);
        wait_done("R3");
        chk(log_n == base_n + 4, "R3", "beat count", 64'(log_n - base_n), 64'd4);
        for (int i = 0; i < 4; i++) begin
            chk(log_we[base_n+i] == 1'b0, "R3", "read beat", 64'(log_we[base_n+i]), 64'd0);
            chk(log_addr[base_n+i] == 29'h1234_5660 + 29'(8*i), "R5", "prefetch beat addr",
                64'(log_addr[base_n+i]), 64'(29'h1234_5660 + 29'(8*i)));
        end
        for (int i = 0; i < 4; i++) begin
            cpu_read(8'hA0 + 8'(8*i), v);
            chk(v == pat(29'h1234_5660 + 29'(8*i)), "R3", "scratchpad filled", v,
                pat(29'h1234_5660 + 29'(8*i)));
        end
    endtask

    task automatic t_writeback();
        int base_n = log_n;
        ack_delay = 2;
        for (int i = 0; i < 4; i++) cpu_write(8'h40 + 8'(8*i), 64'hC0DE_0000_0000_0000 | 64'(i * 32'h1111));
        issue(1'b1, 8'h5B, 29'h1FFF_FFE5);
        wait_done("R4");
        chk(log_n == base_n + 4, "R4", "beat count", 64'(log_n - base_n), 64'd4);
        for (int i = 0; i < 4; i++) begin
            chk(log_we[base_n+i] == 1'b1, "R4", "write beat", 64'(log_we[base_n+i]), 64'd1);
            chk(log_addr[base_n+i] == 29'h1FFF_FFE0 + 29'(8*i), "R5", "write-back beat addr",
                64'(log_addr[base_n+i]), 64'(29'h1FFF_FFE0 + 29'(8*i)));
            chk(log_data[base_n+i] == (64'hC0DE_0000_0000_0000 | 64'(i * 32'h1111)), "R10",
                "write-back beat data", log_data[base_n+i],
                64'hC0DE_0000_0000_0000 | 64'(i * 32'h1111));
        end
    endtask

    task automatic t_conflict();
        logic [63:0] v;
        bit seen = 1'b0;
        ack_delay = 4;
        issue(1'b0, 8'hE0, 29'h0000_0200);
        // Other page during the transfer (R6).
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h08; cpu_wdata = 64'h5555_AAAA_5555_AAAA;
        #1 chk(cpu_stall == 1'b0, "R6", "no stall on other page", 64'(cpu_stall), 64'd0);
        @(negedge clk);
        cpu_we = 1'b0;
        #1 chk(cpu_stall == 1'b0, "R6", "no stall on other-page read", 64'(cpu_stall), 64'd0);
        @(negedge clk);
        cpu_req = 1'b0;
        #1 chk(cpu_rdata == 64'h5555_AAAA_5555_AAAA, "R6", "other-page read during transfer",
               cpu_rdata, 64'h5555_AAAA_5555_AAAA);
        repeat (4) @(negedge clk);
        // Stalled write to the busy page must be dropped (R7).
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'hE0; cpu_wdata = 64'hDEAD_DEAD_DEAD_DEAD;
        #1 chk(cpu_stall == 1'b1, "R7", "stall on busy-page write", 64'(cpu_stall), 64'd1);
        @(negedge clk);
        #1 chk(cpu_stall == 1'b1, "R7", "stall held", 64'(cpu_stall), 64'd1);
        // Switch to a read of the busy page and hold it until the done cycle.
        cpu_we = 1'b0; cpu_addr = 8'hE8;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (xfer_done) begin
                seen = 1'b1;
                chk(cpu_stall == 1'b0, "R8", "stall released in done cycle", 64'(cpu_stall), 64'd0);
            end else if (cpu_stall != 1'b1) begin
                chk(1'b0, "R7", "stall while page busy", 64'(cpu_stall), 64'd1);
            end
        end
        chk(seen, "R8", "done reached", 64'(seen), 64'd1);
        @(negedge clk);
        cpu_req = 1'b0;
        #1 chk(cpu_rdata == pat(29'h208), "R7", "held read served after done", cpu_rdata, pat(29'h208));
        cpu_read(8'hE0, v);
        chk(v == pat(29'h200), "R7", "stalled write not performed", v, pat(29'h200));
    endtask

    task automatic t_busy();
        int base_n = log_n;
        int done_cyc = -1;
        int rdy_cyc = -1;
        ack_delay = 1;
        issue(1'b0, 8'h00, 29'h0000_0040);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b1; cmd_sp_addr = 8'hE0; cmd_ext_addr = 29'h0000_0100;
        for (int c = 0; c < 200 && rdy_cyc < 0; c++) begin
            #1;
            if (xfer_done && done_cyc < 0) done_cyc = c;
            if (cmd_ready) rdy_cyc = c;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(done_cyc >= 0 && rdy_cyc == done_cyc + 1, "R9", "ready returns after done",
            64'(rdy_cyc), 64'(done_cyc + 1));
        wait_done("R9");
        chk(log_n == base_n + 8, "R9", "two transfers completed", 64'(log_n - base_n), 64'd8);
        chk(log_we[base_n+4] == 1'b1 && log_addr[base_n+4] == 29'h100, "R9",
            "queued command started", 64'(log_addr[base_n+4]), 64'h100);
        chk(log_data[base_n+7] == pat(29'h218), "R4", "write-back of prefetched block",
            log_data[base_n+7], pat(29'h218));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_cpu_rw();
        t_prefetch();
        t_writeback();
        t_conflict();
        t_busy();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule